// File: doc/BRIEF.md
# I2S Transmit Controller with Preloadable Sample FIFO

This block is a transmit-only I2S controller that software reaches through a simple 32-bit register bus. Software chooses the sample width and two clock dividers, then writes samples into a 32-word transmit FIFO. Writes into the FIFO are accepted whether or not the transmitter runs, so a burst can be loaded ahead of time and streaming begins the moment the run bit is set. Everything runs on the master clock. The bit clock is the master clock divided by a programmable ratio, and word select is the bit clock divided by a programmable frame length.

Framing is standard I2S. Word select is low for the left channel. The most significant bit of a sample follows each word-select edge by one bit clock. Data changes on the falling edge of the bit clock. Each FIFO word carries one channel sample, right-aligned in its low bits, and samples alternate left then right. When the FIFO runs dry, the serializer keeps both clocks running and sends zeros. A clear command empties the FIFO and restarts the frame from its first bit.

Register map (byte offsets on `bus_addr`): 0x00 format, 0x08 clock dividers, 0x0C fill level, 0x1C run control, 0x20 clear, 0x24 sample data. Every other offset reads zero and ignores writes.

Top module: `i2s_tx_engine`

## Requirements
- R1: After reset, offset 0x00 reads 0x0000000F, offset 0x08 reads 0x00071F1F, offset 0x1C reads 0 and offset 0x0C reads 0.
- R2: Offset 0x00 keeps bits [4:0] (sample width minus one). Offset 0x08 keeps bits [23:16] (master-to-bit-clock divider M), [15:8] (receive frame divider, stored only) and [7:0] (frame divider F). Offset 0x1C keeps bit 0 (transmit run) and bit 1 (receive enable, stored only). Unkept bits and unused offsets (0x10 included) read 0.
- R3: A write to offset 0x24 pushes the word into the FIFO, with or without the run bit. Offset 0x0C bits [5:0] give the fill level, 0 to 32. A write while the level is 32 is dropped and that word is never sent.
- R4: While running, the bit clock has a period of M+1 master-clock cycles. It is low for floor((M+1)/2) cycles and high for the rest, and the low phase comes first after the run bit is set. M must be at least 1.
- R5: Word select changes only at falling bit-clock edges. It is low for the first floor((F+1)/2) bit clocks of each frame of F+1 bit clocks and high for the rest, and the first frame begins low.
- R6: The sample width is W = value at 0x00 bits [4:0] plus 1. Each channel sends bits W-1 down to 0 of its FIFO word, starting one bit clock after its word-select edge, then zeros up to the next sample. Bits above W-1 are ignored. The left sample is popped first.
- R7: A sample slot that starts with the FIFO empty sends all zeros, and the bit clock and word select keep running.
- R8: Clearing bit 0 of 0x1C drives the bit clock, word select and data low from the second master-clock edge after the write on. The FIFO contents are preserved.
- R9: A write to offset 0x20 sets the fill level to 0 at the next edge. It also restarts the clocks and the frame at bit 0 without changing the run bit.
- R10: While the run bit is clear, the bit clock, word select and data outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; also clocks the register bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| sclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Word select (0 = left) |
| sdo_o | output | 1 | Serial data |

## Verification
Register reads are combinational, so the bench samples them one master clock after the write edge. The fill level and the clear take effect one edge after the bus write. Stopping clears the outputs at the second edge, so the bench waits one more falling master edge before it checks them. Serial results are checked bit by bit. An expected queue gives the word-select level and data bit for every bit-clock period, counted from the frame start. A monitor samples the outputs on the falling master edge at each observed bit-clock rise, so it never depends on counting cycles from the enable write. The clock shape is measured in master-clock cycles between observed transitions.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int BUS_W  = 32;
  localparam int ADDR_W = 6;
  localparam int DIV_W  = 8;
  localparam int WID_W  = 5;

  // register byte offsets
  localparam logic [ADDR_W-1:0] A_FMT    = 6'h00;
  localparam logic [ADDR_W-1:0] A_CLKDIV = 6'h08;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_RUN    = 6'h1C;
  localparam logic [ADDR_W-1:0] A_FLUSH  = 6'h20;
  localparam logic [ADDR_W-1:0] A_PUSH   = 6'h24;

  // power-up configuration: 16-bit stereo, 256x master clock
  localparam logic [WID_W-1:0] FMT_RESET  = 5'd15;
  localparam logic [DIV_W-1:0] MDIV_RESET = 8'd7;
  localparam logic [DIV_W-1:0] FDIV_RESET = 8'd31;

  typedef struct packed {
    logic [WID_W-1:0] wm1;
    logic [DIV_W-1:0] mdiv;
    logic [DIV_W-1:0] fdiv;
    logic             run;
  } tx_cfg_t;

  // counter value at which the bit clock goes high
  function automatic logic [DIV_W-1:0] rise_point(input logic [DIV_W-1:0] m);
    return (m - 1'b1) >> 1;
  endfunction

  // number of bit clocks in the left half of a frame
  function automatic logic [DIV_W:0] half_frame(input logic [DIV_W-1:0] f);
    return ({1'b0, f} + 1'b1) >> 1;
  endfunction

  // move a right-aligned sample so its MSB sits at the top bit
  function automatic logic [BUS_W-1:0] msb_align(input logic [BUS_W-1:0] w,
                                                 input logic [WID_W-1:0] wm1);
    return w << (WID_W'(BUS_W-1) - wm1);
  endfunction

endpackage

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs
  import i2s_tx_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [LVL_W-1:0]  level,
  output logic [BUS_W-1:0]  rdata,
  output tx_cfg_t           cfg,
  output logic              push,
  output logic [BUS_W-1:0]  push_data,
  output logic              flush
);

  logic [WID_W-1:0] wm1_q;
  logic [DIV_W-1:0] mdiv_q, rxdiv_q, fdiv_q;
  logic             run_q, rxen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm1_q   <= FMT_RESET;
      mdiv_q  <= MDIV_RESET;
      rxdiv_q <= FDIV_RESET;
      fdiv_q  <= FDIV_RESET;
      run_q   <= 1'b0;
      rxen_q  <= 1'b0;
    end else if (we) begin
      case (addr)
        A_FMT:    wm1_q <= wdata[WID_W-1:0];
        A_CLKDIV: begin
          mdiv_q  <= wdata[3*DIV_W-1:2*DIV_W];
          rxdiv_q <= wdata[2*DIV_W-1:DIV_W];
          fdiv_q  <= wdata[DIV_W-1:0];
        end
        A_RUN: begin
          run_q  <= wdata[0];
          rxen_q <= wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_FMT:    rdata = {{(BUS_W-WID_W){1'b0}}, wm1_q};
      A_CLKDIV: rdata = {{(BUS_W-3*DIV_W){1'b0}}, mdiv_q, rxdiv_q, fdiv_q};
      A_LEVEL:  rdata = {{(BUS_W-LVL_W){1'b0}}, level};
      A_RUN:    rdata = {{(BUS_W-2){1'b0}}, rxen_q, run_q};
      default:  rdata = '0;
    endcase
  end

  assign cfg       = '{wm1: wm1_q, mdiv: mdiv_q, fdiv: fdiv_q, run: run_q};
  assign push      = we && (addr == A_PUSH);
  assign push_data = wdata;
  assign flush     = we && (addr == A_FLUSH);

endmodule

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter  int DW    = 32,
  parameter  int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [DW-1:0]    wdata,
  input  logic             pop,
  output logic [DW-1:0]    rdata,
  output logic [LVL_W-1:0] level,
  output logic             empty
);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign do_push = push && (level != LVL_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] mdiv,
  output logic             sclk,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end    = (cnt >= mdiv);
  assign fall_tick = en && !restart && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (!en || restart) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (at_end) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (cnt == rise_point(mdiv)) sclk <= 1'b1;
    end
  end

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             fall_tick,
  input  logic [WID_W-1:0] wm1,
  input  logic [DIV_W-1:0] fdiv,
  input  logic             fifo_empty,
  input  logic [BUS_W-1:0] fifo_data,
  output logic             pop,
  output logic             load_evt,
  output logic             lrck,
  output logic             sdo
);

  logic [DIV_W-1:0] bcnt, next_b;
  logic [DIV_W:0]   half;
  logic [BUS_W-1:0] sr;

  always_comb begin
    half     = half_frame(fdiv);
    next_b   = (bcnt >= fdiv) ? '0 : bcnt + 1'b1;
    // a slot opens one bit clock after each word-select edge
    load_evt = fall_tick && ((next_b == DIV_W'(1)) ||
                             ({1'b0, next_b} == half + 1'b1));
  end

  assign pop  = load_evt && !fifo_empty;
  assign lrck = en && ({1'b0, bcnt} >= half);
  assign sdo  = sr[BUS_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      sr   <= '0;
    end else if (!en || restart) begin
      bcnt <= '0;
      sr   <= '0;
    end else if (fall_tick) begin
      bcnt <= next_b;
      if (load_evt) sr <= fifo_empty ? '0 : msb_align(fifo_data, wm1);
      else          sr <= sr << 1;
    end
  end

endmodule

// File: rtl/i2s_tx_engine.sv
module i2s_tx_engine
  import i2s_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 32
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic              sdo_o
);

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  tx_cfg_t          cfg;
  logic             tx_run;
  logic             fifo_push, fifo_pop, fifo_flush, fifo_empty;
  logic [BUS_W-1:0] push_word, head_word;
  logic [LVL_W-1:0] fifo_level;
  logic             fall_tick, load_evt;

  assign tx_run = cfg.run;

  i2s_tx_regs #(.LVL_W(LVL_W)) u_regs (
    .clk       (mclk),
    .rst_n     (rst_n),
    .we        (bus_we),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .level     (fifo_level),
    .rdata     (bus_rdata),
    .cfg       (cfg),
    .push      (fifo_push),
    .push_data (push_word),
    .flush     (fifo_flush)
  );

  i2s_tx_fifo #(.DW(BUS_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (mclk),
    .rst_n (rst_n),
    .flush (fifo_flush),
    .push  (fifo_push),
    .wdata (push_word),
    .pop   (fifo_pop),
    .rdata (head_word),
    .level (fifo_level),
    .empty (fifo_empty)
  );

  i2s_tx_clkgen u_clkgen (
    .clk       (mclk),
    .rst_n     (rst_n),
    .en        (tx_run),
    .restart   (fifo_flush),
    .mdiv      (cfg.mdiv),
    .sclk      (sclk_o),
    .fall_tick (fall_tick)
  );

  i2s_tx_serializer u_ser (
    .clk        (mclk),
    .rst_n      (rst_n),
    .en         (tx_run),
    .restart    (fifo_flush),
    .fall_tick  (fall_tick),
    .wm1        (cfg.wm1),
    .fdiv       (cfg.fdiv),
    .fifo_empty (fifo_empty),
    .fifo_data  (head_word),
    .pop        (fifo_pop),
    .load_evt   (load_evt),
    .lrck       (lrck_o),
    .sdo        (sdo_o)
  );

endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
  parameter  int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             mclk,
  input logic             rst_n,
  input logic             tx_run,
  input logic             sclk_o,
  input logic             lrck_o,
  input logic             sdo_o,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_push,
  input logic             fifo_pop,
  input logic             fifo_flush,
  input logic             fall_tick,
  input logic             load_evt
);

  p_level_cap_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));

  p_full_drop_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    (fifo_level == LVL_W'(DEPTH) && fifo_push && !fifo_pop && !fifo_flush)
      |=> (fifo_level == LVL_W'(DEPTH)));

  p_push_count_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    (fifo_push && fifo_level < LVL_W'(DEPTH) && !fifo_pop && !fifo_flush)
      |=> (fifo_level == $past(fifo_level) + 1'b1));

  p_fall_low_r4: assert property (@(posedge mclk) disable iff (!rst_n)
    fall_tick |=> !sclk_o);

  p_ws_on_fall_r5: assert property (@(posedge mclk) disable iff (!rst_n)
    (tx_run && !fifo_flush && !fall_tick) |=> (!tx_run || $stable(lrck_o)));

  p_data_on_fall_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    (tx_run && !fifo_flush && !fall_tick) |=> $stable(sdo_o));

  p_underrun_zero_r7: assert property (@(posedge mclk) disable iff (!rst_n)
    (load_evt && fifo_level == '0) |=> !sdo_o);

  p_flush_empty_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    fifo_flush |=> (fifo_level == '0));

  p_idle_low_r10: assert property (@(posedge mclk) disable iff (!rst_n)
    (!tx_run && !$past(tx_run)) |-> (!sclk_o && !lrck_o && !sdo_o));

endmodule

bind i2s_tx_engine i2s_tx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .mclk       (mclk),
  .rst_n      (rst_n),
  .tx_run     (tx_run),
  .sclk_o     (sclk_o),
  .lrck_o     (lrck_o),
  .sdo_o      (sdo_o),
  .fifo_level (fifo_level),
  .fifo_push  (fifo_push),
  .fifo_pop   (fifo_pop),
  .fifo_flush (fifo_flush),
  .fall_tick  (fall_tick),
  .load_evt   (load_evt)
);

// File: tb/test_i2s_tx_engine.sv
module test_i2s_tx_engine;

  localparam logic [5:0] O_FMT = 6'h00, O_CKR = 6'h08, O_LVL = 6'h0C, O_DMA = 6'h10;
  localparam logic [5:0] O_RUN = 6'h1C, O_CLR = 6'h20, O_DAT = 6'h24;

  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk_o, lrck_o, sdo_o;

  always #4 mclk = ~mclk;

  i2s_tx_engine i_i2s_tx_engine (
    .mclk      (mclk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sclk_o    (sclk_o),
    .lrck_o    (lrck_o),
    .sdo_o     (sdo_o)
  );

  int          total = 0;
  int          bad = 0;
  logic [1:0]  exp_q[$];
  string       tag_q[$];
  logic [31:0] wq[$];
  string       drop_tag = "R7";
  logic        mon_on = 1'b0;
  logic        prev_sclk = 1'b0;

  task automatic check(input string tag, input logic [31:0] got,
                       input logic [31:0] exp, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge mclk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge mclk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [5:0] a,
                          input logic [31:0] exp, input string what);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp, what);
  endtask

  // scoreboard driver: one {ws, data} item per bit clock, frame start first
  task automatic build(input int fdiv, input int wbits, input int nframes);
    for (int f = 0; f < nframes; f++) begin
      for (int p = 0; p <= fdiv; p++) begin
        int h, wi, j;
        logic b;
        string t;
        h = (fdiv + 1) / 2; wi = -1; j = 0;
        if (p == 0) begin
          if (f > 0) begin wi = 2 * (f - 1) + 1; j = fdiv - h; end
        end else if (p <= h) begin
          wi = 2 * f; j = p - 1;
        end else begin
          wi = 2 * f + 1; j = p - h - 1;
        end
        b = 1'b0; t = "R6";
        if (wi >= 0) begin
          if (wi < wq.size()) begin
            if (j < wbits) b = wq[wi][wbits-1-j];
          end else begin
            t = drop_tag;
          end
        end
        exp_q.push_back({(p >= h) ? 1'b1 : 1'b0, b});
        tag_q.push_back(t);
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge mclk);
    mon_on = 1'b0;
  endtask

  task automatic stop_check(input string what);
    wr(O_RUN, 32'h0);
    @(negedge mclk);
    check("R8", {29'b0, sclk_o, lrck_o, sdo_o}, 32'h0, what);
  endtask

  task automatic push_words(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = {8'(i + seed), 8'hA5, 16'(i * 16'h1357 + seed * 16'h0F1 + 16'h00F1)};
      wr(O_DAT, d);
      wq.push_back(d);
    end
  endtask

  task automatic measure(input int m);
    int hi, lo;
    logic last;
    hi = 0; lo = 0;
    wr(O_CKR, {8'h00, 8'(m), 8'h1F, 8'h1F});
    wr(O_RUN, 32'h1);
    last = sclk_o;
    while (1) begin
      @(negedge mclk);
      if (!last && sclk_o) break;
      last = sclk_o;
    end
    while (sclk_o) begin hi++; @(negedge mclk); end
    while (!sclk_o) begin lo++; @(negedge mclk); end
    check("R4", hi, (m + 1) - (m + 1) / 2, "bit clock high cycles");
    check("R4", lo, (m + 1) / 2, "bit clock low cycles");
    stop_check("outputs after clock test");
  endtask

  // scoreboard monitor: compare at each observed bit-clock rise
  always @(negedge mclk) begin
    if (mon_on && !prev_sclk && sclk_o && exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check("R5", {31'b0, lrck_o}, {31'b0, e[1]}, "word select");
      check(t, {31'b0, sdo_o}, {31'b0, e[0]}, "serial bit");
    end
    prev_sclk = sclk_o;
  end

  initial begin
    repeat (150000) @(posedge mclk);
    total++; bad++;
    $display("FAIL R6 watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge mclk);
    rst_n = 1'b1;
    @(negedge mclk);

    // R1 reset values, R10 idle outputs
    rd_check("R1", O_FMT, 32'h0000000F, "format reset");
    rd_check("R1", O_CKR, 32'h00071F1F, "divider reset");
    rd_check("R1", O_RUN, 32'h0, "run reset");
    rd_check("R1", O_LVL, 32'h0, "level reset");
    repeat (20) @(negedge mclk);
    check("R10", {29'b0, sclk_o, lrck_o, sdo_o}, 32'h0, "idle outputs");

    // R2 storage and masking
    wr(O_FMT, 32'hFFFFFFF7);
    rd_check("R2", O_FMT, 32'h17, "format field");
    wr(O_CKR, 32'hAA123456);
    rd_check("R2", O_CKR, 32'h00123456, "divider fields");
    wr(O_DMA, 32'hFFFFFFFF);
    rd_check("R2", O_DMA, 32'h0, "unused offset");
    wr(O_RUN, 32'hFFFFFFFE);
    rd_check("R2", O_RUN, 32'h2, "receive enable bit");
    wr(O_RUN, 32'h0);
    wr(O_FMT, 32'h0F);

    // R4 bit clock shape
    measure(4);
    measure(7);
    wr(O_CKR, 32'h00071F1F);

    // R3 preload while stopped, overflow drop
    wq.delete();
    push_words(1, 3);
    rd_check("R3", O_LVL, 32'd1, "level after one push");
    push_words(31, 4);
    rd_check("R3", O_LVL, 32'd32, "level when full");
    wr(O_DAT, 32'h0000FFFF);
    rd_check("R3", O_LVL, 32'd32, "level after dropped push");
    drop_tag = "R3";
    build(31, 16, 17);
    mon_on = 1'b1;
    wr(O_RUN, 32'h1);
    drain();
    stop_check("outputs after overflow stream");
    rd_check("R3", O_LVL, 32'd0, "level after stream");

    // 24-bit samples, R8 keeps leftovers
    wq.delete();
    wr(O_FMT, 32'd23);
    wr(O_CKR, 32'h00031F2F);
    push_words(6, 9);
    drop_tag = "R7";
    build(47, 24, 2);
    mon_on = 1'b1;
    wr(O_RUN, 32'h1);
    drain();
    stop_check("outputs after 24-bit stream");
    rd_check("R8", O_LVL, 32'd2, "level kept after stop");
    wr(O_CLR, 32'h0);
    rd_check("R9", O_LVL, 32'd0, "level after clear");

    // padding and R7 underrun
    wq.delete();
    wr(O_FMT, 32'd15);
    wr(O_CKR, 32'h00011F3F);
    push_words(3, 21);
    drop_tag = "R7";
    build(63, 16, 3);
    mon_on = 1'b1;
    wr(O_RUN, 32'h1);
    drain();
    stop_check("outputs after underrun stream");

    // R9 clear while running restarts the frame
    wq.delete();
    wr(O_CKR, 32'h00071F1F);
    push_words(4, 30);
    wr(O_RUN, 32'h1);
    repeat (50) @(negedge mclk);
    wq.delete();
    wq.push_back(32'h0000A5C3);
    exp_q.delete(); tag_q.delete();
    build(31, 16, 2);
    wr(O_CLR, 32'h0);
    mon_on = 1'b1;
    rd_check("R9", O_LVL, 32'd0, "level after clear while running");
    rd_check("R9", O_RUN, 32'h1, "run bit kept by clear");
    wr(O_DAT, 32'h0000A5C3);
    drain();
    stop_check("outputs after clear stream");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule